// File: doc/BRIEF.md
# Ternary-Weight Binary-Input Dot Product Engine

This block multiplies a stored vector of ternary weights by a vector of binary inputs. It produces one complete signed dot product every clock cycle. Each weight is -1, 0 or +1 and each input bit is 0 or 1. No multiplier is used: each element's product is its weight, passed through when the input bit is 1 and forced to zero when it is 0. The products are then summed.

The weights live in a bank of registers beside the compute logic. They are loaded one 2-bit code per cycle through a serial shift port and then stay in place while input vectors stream in on a parallel bus. A build-time parameter picks the reduction structure. One option is a balanced binary adder tree of depth log2(N). The other is a chain of 3:2 carry-save compressor stages followed by a single carry-propagate adder. Both options produce bit-identical results.

Top module: `ternary_dot_engine`

## Requirements
- R1: While `rst` is high at a rising edge, the result register and every stored weight are cleared to zero. After reset, an all-ones input vector applied with `load_en` low therefore yields a result of 0.
- R2: Weight codes: 2'b00 means 0, 2'b01 means +1 and 2'b11 means -1. An element whose input bit is 0 contributes 0, whatever its weight.
- R3: On each rising edge with `load_en` high, the bank shifts by one position toward higher element indices, and `wdat` enters element 0. After N such edges, the code shifted in last belongs to element 0 and the code shifted in first belongs to element N-1. While `load_en` is low, the bank is unchanged.
- R4: On a rising edge with `load_en` low, `y` takes the value Σ A_i·B_i, where A_i is the stored weight of element i and B_i is `in_bits[i]`. The result is visible one cycle after the input vector is applied.
- R5: On a rising edge with `load_en` high, `y` keeps its previous value.
- R6: `y` is a two's-complement number of width clog2(N)+2, which is 9 bits for the default N=128. The extreme results +N (all weights +1, all inputs 1) and -N (all weights -1, all inputs 1) are represented exactly.
- R7: The carry-save reduction (`USE_CSA`=1) and the adder-tree reduction (`USE_CSA`=0) give identical `y` for every weight bank and input vector.
- R8: The unused code 2'b10 acts as a weight of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Shift one weight code into the bank this cycle |
| wdat | input | 2 | Weight code entering element 0 |
| in_bits | input | N | Binary input vector, bit i belongs to element i |
| y | output | clog2(N)+2 | Registered signed dot product |

## Verification
The hardest cases to reach from the ports are the extremes of the sum and a single-element contribution at either end of the vector. A full 128-cycle serial load must put every weight at a known position before one input vector can expose a mistake there. The stimulus therefore performs complete directed loads: all +1, all -1, all 2'b10, and a lone +1 placed at element 0 and then probed from both ends of the input bus. Fully random banks and vectors follow. Two instances, one for each reduction variant, are checked against the same bench model on every vector.

// File: rtl/tdp_pkg.sv
package tdp_pkg;

  typedef logic [1:0] wcode_t;

  localparam wcode_t W_ZERO = 2'b00;
  localparam wcode_t W_POS  = 2'b01;
  localparam wcode_t W_NEG  = 2'b11;

  // operand count left after s rounds of 3:2 compression
  function automatic int csa_ops(input int n, input int s);
    int c;
    c = n;
    for (int i = 0; i < s; i++) c = 2 * (c / 3) + (c % 3);
    return c;
  endfunction

  // rounds needed until at most two operands remain
  function automatic int csa_rounds(input int n);
    int c;
    int s;
    c = n;
    s = 0;
    for (int i = 0; i < 64; i++) begin
      if (c > 2) begin
        c = 2 * (c / 3) + (c % 3);
        s++;
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/tdp_weight_bank.sv
module tdp_weight_bank
  import tdp_pkg::*;
#(
  parameter int N = 128
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   load_en,
  input  wcode_t wdat,
  output wcode_t bank [N]
);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) bank[i] <= W_ZERO;
    end else if (load_en) begin
      bank[0] <= wdat;
      for (int i = 1; i < N; i++) bank[i] <= bank[i-1];
    end
  end

  // R3: new code lands in element 0
  p_shift_in_r3: assert property (@(posedge clk) disable iff (rst)
    (load_en && !rst) |=> (bank[0] == $past(wdat)));

  // R3: bank frozen when not loading
  p_bank_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !rst) |=> ($stable(bank[0]) && $stable(bank[N-1])));

endmodule

// File: rtl/tdp_products.sv
module tdp_products
  import tdp_pkg::*;
#(
  parameter int N  = 128,
  parameter int OW = 9
) (
  input  wcode_t                 bank [N],
  input  logic [N-1:0]           in_bits,
  output logic signed [OW-1:0]   prod [N]
);

  for (genvar i = 0; i < N; i++) begin : g_elem
    always_comb begin
      if (!in_bits[i]) prod[i] = '0;
      else if (bank[i] == W_POS) prod[i] = OW'(1);
      else if (bank[i] == W_NEG) prod[i] = '1;
      else prod[i] = '0;
    end
  end

endmodule

// File: rtl/tdp_reduce.sv
module tdp_reduce
  import tdp_pkg::*;
#(
  parameter int N       = 128,
  parameter int OW      = 9,
  parameter bit USE_CSA = 1'b0
) (
  input  logic signed [OW-1:0] prod [N],
  output logic signed [OW-1:0] sum
);

  if (USE_CSA) begin : g_csa
    localparam int NP = (N < 2) ? 2 : N;
    localparam int ST = csa_rounds(NP);
    logic [OW-1:0] ops [ST+1][NP];

    for (genvar k = 0; k < NP; k++) begin : g_leaf
      if (k < N) begin : g_use
        assign ops[0][k] = prod[k];
      end else begin : g_pad
        assign ops[0][k] = '0;
      end
    end

    for (genvar s = 0; s < ST; s++) begin : g_stage
      localparam int C = csa_ops(NP, s);
      localparam int G = C / 3;
      localparam int R = C % 3;
      for (genvar k = 0; k < NP; k++) begin : g_slot
        if (k < 2 * G) begin : g_cmp
          localparam int B = 3 * (k / 2);
          if (k % 2 == 0) begin : g_s
            assign ops[s+1][k] = ops[s][B] ^ ops[s][B+1] ^ ops[s][B+2];
          end else begin : g_c
            assign ops[s+1][k] = ((ops[s][B] & ops[s][B+1]) |
                                  (ops[s][B] & ops[s][B+2]) |
                                  (ops[s][B+1] & ops[s][B+2])) << 1;
          end
        end else if (k < 2 * G + R) begin : g_pass
          assign ops[s+1][k] = ops[s][3 * G + (k - 2 * G)];
        end else begin : g_zero
          assign ops[s+1][k] = '0;
        end
      end
    end

    assign sum = $signed(ops[ST][0] + ops[ST][1]);
  end else begin : g_tree
    logic signed [OW-1:0] node [2*N-1];
    for (genvar i = 0; i < N; i++) begin : g_leaf
      assign node[N-1+i] = prod[i];
    end
    for (genvar j = 0; j < N - 1; j++) begin : g_add
      assign node[j] = node[2*j+1] + node[2*j+2];
    end
    assign sum = node[0];
  end

endmodule

// File: rtl/ternary_dot_engine.sv
module ternary_dot_engine
  import tdp_pkg::*;
#(
  parameter int N       = 128,
  parameter bit USE_CSA = 1'b0,
  localparam int OW     = $clog2(N) + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load_en,
  input  logic [1:0]           wdat,
  input  logic [N-1:0]         in_bits,
  output logic signed [OW-1:0] y
);

  wcode_t               bank [N];
  logic signed [OW-1:0] prod [N];
  logic signed [OW-1:0] sum;

  tdp_weight_bank #(.N(N)) u_bank (
    .clk(clk), .rst(rst), .load_en(load_en), .wdat(wdat), .bank(bank)
  );

  tdp_products #(.N(N), .OW(OW)) u_prod (
    .bank(bank), .in_bits(in_bits), .prod(prod)
  );

  tdp_reduce #(.N(N), .OW(OW), .USE_CSA(USE_CSA)) u_red (
    .prod(prod), .sum(sum)
  );

  always_ff @(posedge clk) begin
    if (rst) y <= '0;
    else if (!load_en) y <= sum;
  end

  // R1: reset clears the result
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (y == '0));

  // R5: result frozen during weight loading
  p_hold_on_load_r5: assert property (@(posedge clk) disable iff (rst)
    (load_en && !rst) |=> $stable(y));

  // R6: result never leaves [-N, +N]
  p_in_range_r6: assert property (@(posedge clk) disable iff (rst)
    (int'(y) <= N) && (int'(y) >= -N));

endmodule

// File: tb/sim_ternary_dot_engine.sv
module sim_ternary_dot_engine;

  localparam int N  = 128;
  localparam int OW = $clog2(N) + 2;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 load_en = 1'b0;
  logic [1:0]           wdat = 2'b00;
  logic [N-1:0]         in_bits = '0;
  logic signed [OW-1:0] y0;
  logic signed [OW-1:0] y1;

  logic [1:0] wmod [N];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ternary_dot_engine #(.N(N), .USE_CSA(1'b0)) u0 (
    .clk(clk), .rst(rst), .load_en(load_en), .wdat(wdat),
    .in_bits(in_bits), .y(y0)
  );

  ternary_dot_engine #(.N(N), .USE_CSA(1'b1)) u1 (
    .clk(clk), .rst(rst), .load_en(load_en), .wdat(wdat),
    .in_bits(in_bits), .y(y1)
  );

  function automatic int ref_dot(input logic [N-1:0] x);
    int acc;
    acc = 0;
    for (int i = 0; i < N; i++) begin
      if (x[i]) begin
        if (wmod[i] == 2'b01) acc += 1;
        else if (wmod[i] == 2'b11) acc -= 1;
      end
    end
    return acc;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // shift element N-1 first so that element i ends at index i
  task automatic load_bank();
    for (int i = N - 1; i >= 0; i--) begin
      @(negedge clk);
      load_en = 1'b1;
      wdat = wmod[i];
    end
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic apply_check(input string tag, input logic [N-1:0] x);
    in_bits = x;
    @(negedge clk);
    check({tag, " tree"}, int'(y0), ref_dot(x));
    check({tag, " csa"},  int'(y1), ref_dot(x));
  endtask

  function automatic logic [N-1:0] rand_vec();
    logic [N-1:0] v;
    for (int k = 0; k < N; k += 32) v[k +: 32] = $urandom();
    return v;
  endfunction

  initial begin
    int unsigned seed;
    int held;
    logic [N-1:0] ones;
    seed = $urandom(32'd2024);
    ones = '1;
    for (int i = 0; i < N; i++) wmod[i] = 2'b00;

    // R1: reset state
    in_bits = ones;
    repeat (3) @(negedge clk);
    check("R1 y in reset tree", int'(y0), 0);
    check("R1 y in reset csa", int'(y1), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 weights cleared tree", int'(y0), 0);
    check("R1 weights cleared csa", int'(y1), 0);

    // R6 / R2: all +1
    for (int i = 0; i < N; i++) wmod[i] = 2'b01;
    load_bank();
    apply_check("R6 all plus", ones);
    check("R6 max value", int'(y0), N);
    apply_check("R2 zero inputs", '0);

    // R5: hold during load of all -1
    apply_check("R4 before load", ones);
    held = int'(y0);
    for (int i = 0; i < N; i++) wmod[i] = 2'b11;
    load_bank();
    check("R5 hold tree", int'(y0), held);
    check("R5 hold csa", int'(y1), held);
    apply_check("R6 all minus", ones);
    check("R6 min value", int'(y1), -N);

    // R8: code 10
    for (int i = 0; i < N; i++) wmod[i] = 2'b10;
    load_bank();
    apply_check("R8 code10 zero", ones);

    // R3: lone +1 at element 0
    for (int i = 0; i < N; i++) wmod[i] = 2'b00;
    wmod[0] = 2'b01;
    load_bank();
    apply_check("R3 elem0 probe", 128'd1);
    check("R3 elem0 value", int'(y0), 1);
    apply_check("R3 top probe", {1'b1, {(N-1){1'b0}}});
    check("R3 top value", int'(y0), 0);

    // R4 / R7: random banks and vectors
    for (int b = 0; b < 6; b++) begin
      for (int i = 0; i < N; i++) wmod[i] = 2'($urandom() % 4);
      load_bank();
      for (int v = 0; v < 20; v++) begin
        apply_check("R4 random", rand_vec());
        check("R7 variants agree", int'(y1), int'(y0));
      end
    end

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule